// File: doc/BRIEF.md
# Double-to-Unsigned Saturating Converter

This unit takes a 64-bit IEEE-754 double-precision operand and turns it into a 32-bit unsigned integer. It does not produce IEEE results. Out-of-range values clamp to the nearest end of the unsigned range. A NaN converts as zero. Denormal inputs are treated as invalid. The unit decodes a 32-bit instruction word to pick one of two variants. One variant rounds with a dynamic rounding mode supplied on a port. The other always rounds toward zero.

Each accepted operation produces a set of registered outputs one clock later:
- the result;
- a write-enable for the destination register;
- invalid and inexact flags;
- a trap request;
- guard and sticky bits, which describe the discarded fraction so that a trap handler can finish the rounding itself.

When invalid trapping is enabled, an invalid operation suppresses the destination write. When inexact trapping is enabled, an inexact operation still writes, but it writes the truncated value.

Top module: `dbl_to_u32_cvt`

## Requirements
- R1: An instruction word is accepted only when `in_valid` is high and all of the following hold: bits [31:26] equal 000100, bits [20:16] are zero, and bits [10:0] equal 01011110100 (dynamic-mode variant) or 01011111000 (toward-zero variant). The outputs register on the next rising edge. For any other word, or when `in_valid` is low, the next cycle shows `out_valid` and every other output at zero.
- R2: While `rst_n` is low, every output is zero.
- R3: A finite normal or zero operand whose rounded value fits in 32 bits returns that value, with no invalid flag. The toward-zero variant ignores `rnd_mode`. The dynamic variant decodes `rnd_mode` as follows: 00 is nearest-even, 01 is toward zero, 10 is toward +infinity, 11 is toward -infinity.
- R4: A positive operand whose rounded value is 2^32 or more, and +infinity, both give 0xFFFFFFFF and set `invalid`.
- R5: A negative operand that rounds to a nonzero magnitude, and -infinity, both give 0 and set `invalid`. A negative operand that rounds to zero gives 0 with `invalid` clear.
- R6: A NaN or a denormal operand gives 0 and sets `invalid`.
- R7: When `invalid` is clear, `guard` is the first fraction bit below the integer LSB and `sticky` is the OR of all lower fraction bits. When `invalid` is set, both are 0.
- R8: `inexact` is set exactly when `invalid` is clear and guard or sticky is nonzero.
- R9: An invalid operation with `inv_trap_en` high raises `trap_req` and drops `wr_en`.
- R10: An inexact operation with `inx_trap_en` high raises `trap_req`, keeps `wr_en` high, and returns the truncated magnitude. For a negative operand, that truncated magnitude is 0.
- R11: In every other accepted case, `wr_en` is 1 and `trap_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word and operand are present |
| instr | input | 32 | Instruction word to decode |
| operand | input | 64 | Double-precision source value |
| rnd_mode | input | 2 | Dynamic rounding mode |
| inv_trap_en | input | 1 | Invalid trap enable |
| inx_trap_en | input | 1 | Inexact trap enable |
| out_valid | output | 1 | A converted result is present |
| result | output | 32 | Converted unsigned integer |
| wr_en | output | 1 | Destination write enable |
| guard | output | 1 | First discarded fraction bit |
| sticky | output | 1 | OR of the lower discarded bits |
| invalid | output | 1 | Invalid-operation flag |
| inexact | output | 1 | Inexact flag |
| trap_req | output | 1 | Trap request |

## Verification
The bench goes after exact ties in nearest-even mode. A design that rounded ties away from zero would turn 2.5 into 3 instead of 2.

It also probes the edge just below 2^32. There, 4294967295.5 must overflow in nearest-even mode and must not overflow toward zero. A missing carry-out check would wrap that value to 0.

Small negative values are driven in every mode. A design that flagged every negative operand as invalid would reject -0.4 rounded to zero, and one that never flagged them would let -0.6 under nearest-even through silently.

NaN, denormal, infinity and trap-enable combinations catch two kinds of error: a wrong saturation end, and a write or guard/sticky value leaking out of an invalid trap.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
    localparam int OPW   = 64;
    localparam int RESW  = 32;
    localparam int EXPW  = 11;
    localparam int FRACW = 52;
    localparam int MANTW = FRACW + 1;
    localparam int BIAS  = 1023;
    localparam int UEW   = EXPW + 2;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_PINF = 2'b10,
        RM_NINF = 2'b11
    } rmode_e;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_NORM,
        CL_DENORM,
        CL_INF,
        CL_NAN
    } opclass_e;

    typedef struct packed {
        logic            vld;
        logic [RESW-1:0] res;
        logic            wr;
        logic            grd;
        logic            stk;
        logic            inv;
        logic            inx;
        logic            trap;
    } cvt_out_t;
endpackage

// File: rtl/cvt_decode.sv
module cvt_decode (
    input  logic [31:0] instr,
    output logic        hit,
    output logic        trunc
);
    localparam logic [5:0]  PRIMARY = 6'b000100;
    localparam logic [10:0] XO_CUR  = 11'b01011110100;
    localparam logic [10:0] XO_RZ   = 11'b01011111000;

    logic [10:0] xo;
    logic        unused_regs;

    assign xo          = instr[10:0];
    assign unused_regs = ^{instr[25:21], instr[15:11]};

    always_comb begin
        hit   = (instr[31:26] == PRIMARY) && (instr[20:16] == 5'd0) &&
                ((xo == XO_CUR) || (xo == XO_RZ));
        trunc = (xo == XO_RZ);
    end
endmodule

// File: rtl/cvt_unpack.sv
module cvt_unpack
    import cvt_pkg::*;
(
    input  logic [OPW-1:0]        operand,
    output logic                  sign,
    output opclass_e              cls,
    output logic signed [UEW-1:0] uexp,
    output logic [MANTW-1:0]      mant
);
    localparam logic signed [UEW-1:0] BIAS_S = UEW'(BIAS);
    localparam logic [EXPW-1:0]       EXP_MAX = '1;

    logic [EXPW-1:0]  ex;
    logic [FRACW-1:0] fr;

    assign sign = operand[OPW-1];
    assign ex   = operand[OPW-2 -: EXPW];
    assign fr   = operand[FRACW-1:0];

    always_comb begin
        uexp = $signed({2'b00, ex}) - BIAS_S;
        mant = {1'b1, fr};
        if (ex == '0)
            cls = (fr == '0) ? CL_ZERO : CL_DENORM;
        else if (ex == EXP_MAX)
            cls = (fr == '0) ? CL_INF : CL_NAN;
        else
            cls = CL_NORM;
    end
endmodule

// File: rtl/cvt_round.sv
module cvt_round
    import cvt_pkg::*;
(
    input  logic                  sign,
    input  opclass_e              cls,
    input  logic signed [UEW-1:0] uexp,
    input  logic [MANTW-1:0]      mant,
    input  rmode_e                mode,
    output logic [RESW-1:0]       res_rnd,
    output logic [RESW-1:0]       res_trunc,
    output logic                  grd,
    output logic                  stk,
    output logic                  inv,
    output logic                  inx
);
    localparam int SHW = $clog2(MANTW + 1);
    localparam logic signed [UEW-1:0] RESW_S = UEW'(RESW);
    localparam logic signed [UEW-1:0] NEG1   = '1;
    localparam logic [MANTW-1:0]      ONE    = MANTW'(1);
    localparam logic [RESW-1:0]       SAT_HI = '1;

    logic [SHW-1:0]   sh;
    logic [MANTW-1:0] shifted;
    logic [MANTW-1:0] mask;
    logic [RESW-1:0]  tint;
    logic [RESW:0]    rnd;
    logic             g, s, ovf, inc;

    // Split the magnitude into integer part, guard and sticky.
    always_comb begin
        sh      = '0;
        shifted = '0;
        mask    = '0;
        tint    = '0;
        g       = 1'b0;
        s       = 1'b0;
        ovf     = 1'b0;
        if (uexp >= RESW_S) begin
            ovf = 1'b1;
        end else if (!uexp[UEW-1]) begin
            sh      = SHW'(FRACW) - uexp[SHW-1:0];
            shifted = mant >> sh;
            tint    = shifted[RESW-1:0];
            g       = mant[sh - SHW'(1)];
            mask    = (ONE << (sh - SHW'(1))) - ONE;
            s       = |(mant & mask);
        end else if (uexp == NEG1) begin
            g = 1'b1;
            s = |mant[FRACW-1:0];
        end else begin
            s = 1'b1;
        end
    end

    // Increment decision, saturation and flags.
    always_comb begin
        unique case (mode)
            RM_NEAR: inc = g & (s | tint[0]);
            RM_ZERO: inc = 1'b0;
            RM_PINF: inc = ~sign & (g | s);
            RM_NINF: inc = sign & (g | s);
            default: inc = 1'b0;
        endcase
        rnd       = {1'b0, tint} + {{RESW{1'b0}}, inc};
        res_rnd   = '0;
        res_trunc = sign ? '0 : tint;
        inv       = 1'b0;
        inx       = 1'b0;
        grd       = 1'b0;
        stk       = 1'b0;
        unique case (cls)
            CL_ZERO: res_rnd = '0;
            CL_DENORM, CL_NAN: inv = 1'b1;
            CL_INF: begin
                inv     = 1'b1;
                res_rnd = sign ? '0 : SAT_HI;
            end
            CL_NORM: begin
                if (ovf) begin
                    inv     = 1'b1;
                    res_rnd = sign ? '0 : SAT_HI;
                end else if (sign) begin
                    inv = (rnd != '0);
                end else if (rnd[RESW]) begin
                    inv     = 1'b1;
                    res_rnd = SAT_HI;
                end else begin
                    res_rnd = rnd[RESW-1:0];
                end
                if (!inv) begin
                    grd = g;
                    stk = s;
                    inx = g | s;
                end
            end
            default: inv = 1'b1;
        endcase
    end
endmodule

// File: rtl/dbl_to_u32_cvt.sv
module dbl_to_u32_cvt
    import cvt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [OPW-1:0]  operand,
    input  logic [1:0]      rnd_mode,
    input  logic            inv_trap_en,
    input  logic            inx_trap_en,
    output logic            out_valid,
    output logic [RESW-1:0] result,
    output logic            wr_en,
    output logic            guard,
    output logic            sticky,
    output logic            invalid,
    output logic            inexact,
    output logic            trap_req
);
    logic                  hit, trunc, fire;
    logic                  sign;
    opclass_e              cls;
    logic signed [UEW-1:0] uexp;
    logic [MANTW-1:0]      mant;
    rmode_e                mode;
    logic [RESW-1:0]       res_rnd, res_trunc;
    logic                  grd, stk, inv, inx;
    cvt_out_t              out_d, out_q;

    cvt_decode u_dec (
        .instr (instr),
        .hit   (hit),
        .trunc (trunc)
    );

    cvt_unpack u_unp (
        .operand (operand),
        .sign    (sign),
        .cls     (cls),
        .uexp    (uexp),
        .mant    (mant)
    );

    assign fire = in_valid & hit;
    assign mode = trunc ? RM_ZERO : rmode_e'(rnd_mode);

    cvt_round u_rnd (
        .sign      (sign),
        .cls       (cls),
        .uexp      (uexp),
        .mant      (mant),
        .mode      (mode),
        .res_rnd   (res_rnd),
        .res_trunc (res_trunc),
        .grd       (grd),
        .stk       (stk),
        .inv       (inv),
        .inx       (inx)
    );

    always_comb begin
        out_d = '0;
        if (fire) begin
            out_d.vld  = 1'b1;
            out_d.inv  = inv;
            out_d.inx  = inx;
            out_d.grd  = grd;
            out_d.stk  = stk;
            out_d.trap = (inv & inv_trap_en) | (inx & inx_trap_en);
            out_d.wr   = ~(inv & inv_trap_en);
            out_d.res  = (inx & inx_trap_en) ? res_trunc : res_rnd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid = out_q.vld;
    assign result    = out_q.res;
    assign wr_en     = out_q.wr;
    assign guard     = out_q.grd;
    assign sticky    = out_q.stk;
    assign invalid   = out_q.inv;
    assign inexact   = out_q.inx;
    assign trap_req  = out_q.trap;

    // R1: an idle cycle leaves every output quiet
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |=> !out_valid && !wr_en && !trap_req && !invalid && !inexact);

    // R4: +infinity saturates high
    p_pinf_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fire && cls == CL_INF && !sign |=> result == '1 && invalid);

    // R6: NaN reads as zero
    p_nan_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fire && cls == CL_NAN |=> result == '0 && invalid);

    // R8: inexact never accompanies invalid
    p_inx_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> !inexact && !guard && !sticky);

    // R9: an enabled invalid trap blocks the write
    p_inv_trap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fire && inv_trap_en |=> !(invalid && wr_en));
endmodule

// File: tb/sim_dbl_to_u32_cvt.sv
`timescale 1ns/1ps
module sim_dbl_to_u32_cvt;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] instr;
    logic [63:0] operand;
    logic [1:0]  rnd_mode;
    logic        inv_trap_en, inx_trap_en;
    logic        out_valid, wr_en, guard, sticky, invalid, inexact, trap_req;
    logic [31:0] result;

    int errors = 0;
    int checks = 0;

    typedef struct {
        bit          vld;
        logic [31:0] res;
        bit          wr, g, s, inv, inx, trap;
        string       tag;
    } exp_t;

    exp_t pend;
    bit   have_pend = 0;

    always #5 clk = ~clk;

    dbl_to_u32_cvt u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .operand(operand), .rnd_mode(rnd_mode), .inv_trap_en(inv_trap_en),
        .inx_trap_en(inx_trap_en), .out_valid(out_valid), .result(result),
        .wr_en(wr_en), .guard(guard), .sticky(sticky), .invalid(invalid),
        .inexact(inexact), .trap_req(trap_req)
    );

    localparam logic [10:0] XC = 11'b01011110100;
    localparam logic [10:0] XZ = 11'b01011111000;

    function automatic logic [31:0] mk(bit rz);
        return {6'b000100, 5'd3, 5'd0, 5'd9, rz ? XZ : XC};
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    function automatic exp_t model(bit iv, logic [31:0] ins, logic [63:0] op,
                                   logic [1:0] md, bit ie, bit xe);
        exp_t e;
        real a, tr, fr;
        longint ti, mag;
        bit g, s, up, sg;
        logic [1:0] m;
        logic [10:0] ex;
        e.vld = 0; e.res = '0; e.wr = 0; e.g = 0; e.s = 0;
        e.inv = 0; e.inx = 0; e.trap = 0; e.tag = "R1";
        if (!(iv && ins[31:26] == 6'b000100 && ins[20:16] == 5'd0 &&
              (ins[10:0] == XC || ins[10:0] == XZ))) return e;
        e.vld = 1; e.tag = "R3";
        m = (ins[10:0] == XZ) ? 2'b01 : md;
        sg = op[63]; ex = op[62:52];
        g = 0; s = 0; ti = 0;
        if (ex == 0 && op[51:0] == 0) begin
            e.res = 0;
        end else if (ex == 0 || (ex == 11'h7FF && op[51:0] != 0)) begin
            e.inv = 1; e.tag = "R6";
        end else if (ex == 11'h7FF) begin
            e.inv = 1; e.res = sg ? 32'h0 : 32'hFFFFFFFF; e.tag = sg ? "R5" : "R4";
        end else begin
            a = $bitstoreal(op);
            if (a < 0.0) a = -a;
            if (a >= 4294967296.0) begin
                e.inv = 1; e.res = sg ? 32'h0 : 32'hFFFFFFFF; e.tag = sg ? "R5" : "R4";
            end else begin
                tr = $floor(a);
                fr = a - tr;
                ti = longint'(tr);
                g  = (fr >= 0.5);
                s  = g ? (fr > 0.5) : (fr > 0.0);
                case (m)
                    2'b00: up = g && (s || ti[0]);
                    2'b01: up = 0;
                    2'b10: up = !sg && (g || s);
                    default: up = sg && (g || s);
                endcase
                mag = ti + (up ? 1 : 0);
                if (sg) begin
                    e.tag = "R5";
                    if (mag != 0) e.inv = 1;
                end else if (mag >= 64'd4294967296) begin
                    e.inv = 1; e.res = 32'hFFFFFFFF; e.tag = "R4";
                end else begin
                    e.res = mag[31:0];
                end
                if (!e.inv) begin
                    e.g = g; e.s = s; e.inx = g || s;
                end
            end
        end
        e.trap = (e.inv && ie) || (e.inx && xe);
        e.wr   = !(e.inv && ie);
        if (e.inx && xe) begin
            e.res = sg ? 32'h0 : ti[31:0];
            e.tag = "R10";
        end
        return e;
    endfunction

    task automatic compare(exp_t e);
        string tt, tf;
        tt = e.trap && e.inv ? "R9" : (e.trap ? "R10" : "R11");
        tf = e.vld ? tt : "R1";
        chk(out_valid == e.vld, "R1", "out_valid", out_valid, e.vld);
        chk(result == e.res, e.tag, "result", result, e.res);
        chk(invalid == e.inv, e.tag, "invalid", invalid, e.inv);
        chk(guard == e.g, "R7", "guard", guard, e.g);
        chk(sticky == e.s, "R7", "sticky", sticky, e.s);
        chk(inexact == e.inx, "R8", "inexact", inexact, e.inx);
        chk(trap_req == e.trap, tf, "trap_req", trap_req, e.trap);
        chk(wr_en == e.wr, tf, "wr_en", wr_en, e.wr);
    endtask

    task automatic apply(bit iv, logic [31:0] ins, logic [63:0] op,
                         logic [1:0] md, bit ie, bit xe);
        @(negedge clk);
        if (have_pend) compare(pend);
        in_valid = iv; instr = ins; operand = op; rnd_mode = md;
        inv_trap_en = ie; inx_trap_en = xe;
        pend = model(iv, ins, op, md, ie, xe);
        have_pend = 1;
    endtask

    task automatic all_modes(real v, bit ie, bit xe);
        for (int k = 0; k < 4; k++) apply(1, mk(0), $realtobits(v), 2'(k), ie, xe);
        apply(1, mk(1), $realtobits(v), 2'b00, ie, xe);
    endtask

    initial begin
        #(200000 * 10);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 0; in_valid = 0; instr = '0; operand = '0; rnd_mode = '0;
        inv_trap_en = 0; inx_trap_en = 0;
        repeat (3) @(negedge clk);
        // R2: outputs held at zero in reset
        chk({out_valid, result, wr_en, guard, sticky, invalid, inexact, trap_req} == '0,
            "R2", "reset outputs", {out_valid, result}, 0);
        @(negedge clk);
        rst_n = 1;
        // R3 ties and rounding modes
        all_modes(2.5, 0, 0);
        all_modes(1.5, 0, 0);
        all_modes(0.75, 0, 0);
        all_modes(123456.25, 0, 0);
        all_modes(0.0, 0, 0);
        all_modes(-0.0, 0, 0);
        // R5 small negatives
        all_modes(-0.4, 0, 0);
        all_modes(-0.6, 0, 0);
        all_modes(-0.5, 0, 0);
        all_modes(-3.0, 0, 0);
        // R4 edge of range
        all_modes(4294967295.0, 0, 0);
        all_modes(4294967295.5, 0, 0);
        all_modes(4294967295.25, 0, 0);
        all_modes(4294967296.0, 0, 0);
        all_modes(1.0e300, 0, 0);
        // R4 R5 R6 special operands
        apply(1, mk(0), 64'h7FF0000000000000, 2'b00, 0, 0);
        apply(1, mk(0), 64'hFFF0000000000000, 2'b00, 0, 0);
        apply(1, mk(1), 64'h7FF8000000000001, 2'b00, 0, 0);
        apply(1, mk(0), 64'h0000000000000001, 2'b10, 0, 0);
        apply(1, mk(0), 64'h800FFFFFFFFFFFFF, 2'b11, 0, 0);
        // R9 invalid traps
        apply(1, mk(0), 64'h7FF8000000000000, 2'b00, 1, 0);
        apply(1, mk(0), $realtobits(5.0e9), 2'b00, 1, 1);
        apply(1, mk(1), $realtobits(-7.5), 2'b00, 1, 0);
        // R10 inexact traps
        all_modes(3.7, 0, 1);
        all_modes(-0.3, 0, 1);
        all_modes(4294967295.5, 0, 1);
        all_modes(8.0, 1, 1);
        // R1 rejected encodings
        apply(1, {mk(0)[31:11], 11'b01011110101}, $realtobits(9.0), 2'b00, 0, 0);
        apply(1, {6'b000101, mk(0)[25:0]}, $realtobits(9.0), 2'b00, 0, 0);
        apply(1, mk(0) | 32'h00010000, $realtobits(9.0), 2'b00, 0, 0);
        apply(0, mk(0), $realtobits(9.0), 2'b00, 1, 1);
        // random sweep
        for (int i = 0; i < 4000; i++) begin
            logic [63:0] op;
            logic [10:0] ex;
            int sel;
            sel = $urandom_range(0, 9);
            if (sel == 0)      ex = 11'($urandom_range(0, 2047));
            else if (sel < 3)  ex = 11'($urandom_range(1000, 1023));
            else               ex = 11'($urandom_range(1023, 1056));
            op = {1'($urandom_range(0, 1)), ex, 20'($urandom), 32'($urandom)};
            if ($urandom_range(0, 2) == 0) op[29:0] = '0;
            apply(1, mk(1'($urandom_range(0, 1))), op, 2'($urandom_range(0, 3)),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end
        apply(0, '0, '0, 2'b00, 0, 0);
        apply(0, '0, '0, 2'b00, 0, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule